// File: doc/BRIEF.md
# Card Command Response Capture

This block sends one command to a memory card model and collects the reply. A command word carries the command index and two response options. When it is written with its enable bit set, the block latches the 32-bit argument and raises a one-cycle request toward the card side. It then either finishes at once, when no reply is expected, or waits for a stream of reply bytes that ends with an end strobe and a byte count.

On completion the block decides whether the reply is acceptable. It packs an accepted reply into four 32-bit response words and posts exactly one completion flag in its status byte. The enable bit in the readable copy of the command word drops back to zero when the command finishes, whatever the outcome. While a command is in flight the block reports busy and ignores any further command write.

Top module: `cmd_rsp_capture`

## Requirements
- R1: After reset the status byte, all four response words and the stored command word are zero, and busy, done and the card request are low.
- R2: A command write with bit 10 clear, made while idle, stores the whole word in the command copy and starts nothing: no card request, busy stays low, status is unchanged.
- R3: A command write with bit 10 set, made while idle, raises busy and card_req on the next cycle. card_req lasts one cycle and carries the index from bits [5:0] and the latched argument. The status byte reads zero from that cycle on.
- R4: When bit 6 (reply expected) of the command is clear, status bit 7 is set and done pulses one cycle after the card request, and the response words keep their contents.
- R5: A reply of 4 bytes, when bit 7 (long reply) is clear, sets status bit 6. The bytes go into word 0 with the first byte in bits [31:24] and the fourth in bits [7:0]. Words 1 to 3 become zero.
- R6: A reply of 16 bytes fills words 0 to 3 in arrival order, each most-significant byte first, with bit 0 of word 3 forced to zero, and sets status bit 6.
- R7: When a reply is expected and the reported count is 0, or is 4 while bit 7 is set, or is any value other than 4 or 16, status bit 2 (timeout) is set and the response words keep their previous contents.
- R8: A 16-byte reply to a command with bit 7 clear is accepted as a long reply (R6 packing, status bit 6).
- R9: Bit 10 of the command copy stays set for as long as busy is high. It reads zero from the cycle in which done pulses, and done coincides with busy going low.
- R10: A command write made while busy leaves the command copy, the card argument and the command in flight unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 11 | Command word: [5:0] index, 6 reply expected, 7 long reply, 10 enable |
| cmd_arg | input | 32 | Command argument, latched when a command starts |
| busy | output | 1 | A command is in flight |
| cmd_q | output | 11 | Stored command word; bit 10 clears on completion |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Bit 2 timeout, bit 6 reply accepted, bit 7 sent without reply; other bits zero |
| rsp_words | output | 4x32 | Response words 0 to 3 |
| card_req | output | 1 | One-cycle command request to the card side |
| card_idx | output | 6 | Command index for the card |
| card_arg | output | 32 | Argument for the card |
| rsp_vld | input | 1 | A reply byte is present |
| rsp_byte | input | 8 | Reply byte |
| rsp_end | input | 1 | Reply finished; rsp_len is valid |
| rsp_len | input | 8 | Number of reply bytes reported by the card side |

## Verification
A command written in cycle N shows card_req, busy and the cleared status in cycle N+1. For a command with no reply, done, status bit 7 and the cleared enable bit are due in cycle N+2. For a command with a reply, the words, flags and done are due in the cycle after the one in which rsp_end is seen. The bench drives inputs and reads outputs on the falling edge and steps exactly these counts before each direct check. The expected status and words for each command go into a queue when the driver issues it, and a monitor pops one entry on every done pulse, so a result that arrives a cycle early or late is compared against the wrong state or leaves the queue unbalanced.

// File: rtl/cmdcap_pkg.sv
package cmdcap_pkg;
   // command word bit positions (decoded by software and the card side)
   localparam int CB_RSP  = 6;
   localparam int CB_LONG = 7;
   localparam int CB_EN   = 10;
   // status bit positions
   localparam int SB_TIMEOUT = 2;
   localparam int SB_RSPOK   = 6;
   localparam int SB_SENT    = 7;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ISSUE = 2'd1,
      PH_WAIT  = 2'd2
   } cmd_phase_e;
endpackage

// File: rtl/cmdcap_ctrl.sv
module cmdcap_ctrl
   import cmdcap_pkg::*;
#(
   parameter int CMD_W = 11,
   parameter int ARG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic [ARG_W-1:0] cmd_arg,
   input  logic             rsp_end,
   output logic [CMD_W-1:0] cmd_q,
   output logic [ARG_W-1:0] card_arg,
   output logic             card_req,
   output logic             busy,
   output logic             done,
   output logic             start,
   output logic             capture_open,
   output logic             fin_rsp,
   output logic             fin_nores
);
   cmd_phase_e phase;
   logic       store;

   assign store        = cmd_wr && (phase == PH_IDLE);
   assign start        = store && cmd_word[CB_EN];
   assign card_req     = (phase == PH_ISSUE);
   assign busy         = (phase != PH_IDLE);
   assign capture_open = (phase == PH_WAIT);
   assign fin_nores    = (phase == PH_ISSUE) && !cmd_q[CB_RSP];
   assign fin_rsp      = (phase == PH_WAIT) && rsp_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cmd_q    <= '0;
         card_arg <= '0;
         done     <= 1'b0;
      end else begin
         done <= fin_nores || fin_rsp;
         if (store) cmd_q <= cmd_word;
         if (start) begin
            card_arg <= cmd_arg;
            phase    <= PH_ISSUE;
         end else if (phase == PH_ISSUE) begin
            if (cmd_q[CB_RSP]) begin
               phase <= PH_WAIT;
            end else begin
               phase        <= PH_IDLE;
               cmd_q[CB_EN] <= 1'b0;
            end
         end else if (fin_rsp) begin
            phase        <= PH_IDLE;
            cmd_q[CB_EN] <= 1'b0;
         end
      end
   end

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_req |=> !card_req);
   // R9
   en_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cmd_q[CB_EN]);
   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> $stable(card_arg));
endmodule

// File: rtl/cmdcap_bytebuf.sv
module cmdcap_bytebuf #(
   parameter int MAX_BYTES = 16,
   parameter int BYTE_W    = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clear,
   input  logic                              open,
   input  logic                              vld,
   input  logic [BYTE_W-1:0]                 din,
   output logic [MAX_BYTES-1:0][BYTE_W-1:0]  bytes_q
);
   localparam int PW = $clog2(MAX_BYTES + 1);

   logic [PW-1:0] ptr;
   logic          wr;

   assign wr = open && vld && (ptr < PW'(MAX_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         bytes_q <= '0;
      end else if (clear) begin
         ptr <= '0;
      end else if (wr) begin
         ptr <= ptr + 1'b1;
         for (int i = 0; i < MAX_BYTES; i++) begin
            if (ptr == PW'(i)) bytes_q[i] <= din;
         end
      end
   end

   // R6
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PW'(MAX_BYTES));
endmodule

// File: rtl/cmdcap_assemble.sv
module cmdcap_assemble
   import cmdcap_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int RSP_WORDS = 4,
   parameter int BYTE_W    = 8,
   parameter int LEN_W     = 8,
   parameter int STAT_W    = 8
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       start,
   input  logic                                       fin_rsp,
   input  logic                                       fin_nores,
   input  logic                                       long_req,
   input  logic [LEN_W-1:0]                           len,
   input  logic [RSP_WORDS*WORD_W/BYTE_W-1:0][BYTE_W-1:0] bytes_q,
   output logic [RSP_WORDS-1:0][WORD_W-1:0]           words,
   output logic [STAT_W-1:0]                          status
);
   localparam int BPW         = WORD_W / BYTE_W;
   localparam int SHORT_BYTES = BPW;
   localparam int LONG_BYTES  = RSP_WORDS * BPW;

   logic [RSP_WORDS-1:0][WORD_W-1:0] long_w, short_w;
   logic is_short, is_long, len_ok;

   genvar w, j;
   generate
      for (w = 0; w < RSP_WORDS; w++) begin : g_word
         logic [WORD_W-1:0] packed_w;
         for (j = 0; j < BPW; j++) begin : g_byte
            assign packed_w[WORD_W-1-j*BYTE_W -: BYTE_W] = bytes_q[w*BPW + j];
         end
         if (w == RSP_WORDS - 1) begin : g_last
            assign long_w[w] = {packed_w[WORD_W-1:1], 1'b0};
         end else begin : g_mid
            assign long_w[w] = packed_w;
         end
         if (w == 0) begin : g_first
            assign short_w[w] = packed_w;
         end else begin : g_rest
            assign short_w[w] = '0;
         end
      end
   endgenerate

   assign is_short = (len == LEN_W'(SHORT_BYTES));
   assign is_long  = (len == LEN_W'(LONG_BYTES));
   assign len_ok   = is_long || (is_short && !long_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words  <= '0;
         status <= '0;
      end else if (start) begin
         status <= '0;
      end else if (fin_nores) begin
         status[SB_SENT] <= 1'b1;
      end else if (fin_rsp) begin
         if (len_ok) begin
            words             <= is_long ? long_w : short_w;
            status[SB_RSPOK]  <= 1'b1;
         end else begin
            status[SB_TIMEOUT] <= 1'b1;
         end
      end
   end

   // R7
   one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status));
   // R6
   last_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      words[RSP_WORDS-1][0] == 1'b0);
   // R7
   keep_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_rsp && !len_ok) |=> $stable(words));
endmodule

// File: rtl/cmd_rsp_capture.sv
module cmd_rsp_capture
   import cmdcap_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int RSP_WORDS = 4,
   parameter int BYTE_W    = 8,
   parameter int IDX_W     = 6,
   parameter int CMD_W     = 11,
   parameter int LEN_W     = 8,
   parameter int STAT_W    = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cmd_wr,
   input  logic [CMD_W-1:0]                 cmd_word,
   input  logic [WORD_W-1:0]                cmd_arg,
   output logic                             busy,
   output logic [CMD_W-1:0]                 cmd_q,
   output logic                             done,
   output logic [STAT_W-1:0]                status,
   output logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_words,
   output logic                             card_req,
   output logic [IDX_W-1:0]                 card_idx,
   output logic [WORD_W-1:0]                card_arg,
   input  logic                             rsp_vld,
   input  logic [BYTE_W-1:0]                rsp_byte,
   input  logic                             rsp_end,
   input  logic [LEN_W-1:0]                 rsp_len
);
   localparam int MAX_BYTES = RSP_WORDS * WORD_W / BYTE_W;

   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_word
         $error("word width must be a whole number of bytes");
      end
      if (CMD_W <= CB_EN || IDX_W > CB_RSP) begin : g_bad_cmd
         $error("command word too narrow for its fields");
      end
      if (STAT_W <= SB_SENT) begin : g_bad_stat
         $error("status too narrow");
      end
      if ((1 << LEN_W) <= MAX_BYTES) begin : g_bad_len
         $error("length field cannot hold a long reply count");
      end
   endgenerate

   logic start, open, fin_rsp, fin_nores;
   logic [MAX_BYTES-1:0][BYTE_W-1:0] bytes_q;

   cmdcap_ctrl #(.CMD_W(CMD_W), .ARG_W(WORD_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .cmd_arg(cmd_arg), .rsp_end(rsp_end), .cmd_q(cmd_q),
      .card_arg(card_arg), .card_req(card_req), .busy(busy), .done(done),
      .start(start), .capture_open(open), .fin_rsp(fin_rsp),
      .fin_nores(fin_nores)
   );

   cmdcap_bytebuf #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clear(start), .open(open),
      .vld(rsp_vld), .din(rsp_byte), .bytes_q(bytes_q)
   );

   cmdcap_assemble #(.WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS), .BYTE_W(BYTE_W),
                     .LEN_W(LEN_W), .STAT_W(STAT_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .start(start), .fin_rsp(fin_rsp),
      .fin_nores(fin_nores), .long_req(cmd_q[CB_LONG]), .len(rsp_len),
      .bytes_q(bytes_q), .words(rsp_words), .status(status)
   );

   assign card_idx = cmd_q[IDX_W-1:0];

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !cmd_q[CB_EN]));
   // R4
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != '0));
endmodule

// File: tb/cmd_rsp_capture_tb.sv
module cmd_rsp_capture_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic              cmd_wr = 1'b0;
   logic [10:0]       cmd_word = '0;
   logic [31:0]       cmd_arg = '0;
   logic              busy, done, card_req;
   logic [10:0]       cmd_q;
   logic [7:0]        status;
   logic [3:0][31:0]  rsp_words;
   logic [5:0]        card_idx;
   logic [31:0]       card_arg;
   logic              rsp_vld = 1'b0;
   logic [7:0]        rsp_byte = '0;
   logic              rsp_end = 1'b0;
   logic [7:0]        rsp_len = '0;

   cmd_rsp_capture u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .cmd_arg(cmd_arg), .busy(busy), .cmd_q(cmd_q), .done(done),
      .status(status), .rsp_words(rsp_words), .card_req(card_req),
      .card_idx(card_idx), .card_arg(card_arg), .rsp_vld(rsp_vld),
      .rsp_byte(rsp_byte), .rsp_end(rsp_end), .rsp_len(rsp_len)
   );

   typedef struct {
      logic [7:0]       st;
      logic [3:0][31:0] w;
   } exp_t;

   exp_t             sb[$];
   logic [3:0][31:0] model_w = '0;
   int               n_chk = 0;
   int               n_bad = 0;
   int               n_push = 0;
   int               n_pop = 0;
   bit               finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: one scoreboard entry per completion pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R4", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            n_pop++;
            chk(status == e.st, "R7", "status", status, e.st);
            chk(rsp_words == e.w, "R5", "words", rsp_words, e.w);
            chk(!busy && !cmd_q[10], "R9", "busy/enable at done",
                {busy, cmd_q[10]}, 0);
         end
      end
   end

   task automatic issue(input logic [10:0] w, input logic [31:0] a,
                        input int nb, input logic [7:0] len,
                        input logic [7:0] seed, input bit poke);
      logic [7:0] bb [16];
      exp_t e;
      for (int k = 0; k < 16; k++) bb[k] = seed + 8'(k * 29);
      if (w[10]) begin
         e.w  = model_w;
         e.st = 8'h00;
         if (!w[6]) e.st = 8'h80;
         else if ((len == 8'd4 && !w[7]) || len == 8'd16) begin
            e.st = 8'h40;
            for (int x = 0; x < 4; x++)
               e.w[x] = (len == 8'd16 || x == 0) ?
                        {bb[4*x], bb[4*x+1], bb[4*x+2], bb[4*x+3]} : 32'h0;
            if (len == 8'd16) e.w[3][0] = 1'b0;
         end else e.st = 8'h04;
         model_w = e.w;
         sb.push_back(e);
         n_push++;
      end
      @(negedge clk);
      cmd_wr = 1'b1; cmd_word = w; cmd_arg = a;
      @(negedge clk);
      cmd_wr = 1'b0;
      if (!w[10]) begin
         chk(cmd_q == w, "R2", "stored word", cmd_q, w);
         chk(!busy && !card_req, "R2", "no start", {busy, card_req}, 0);
         return;
      end
      chk(card_req && busy, "R3", "request", {card_req, busy}, 2'b11);
      chk(card_idx == w[5:0] && card_arg == a, "R3", "index/arg",
          {card_idx, card_arg}, {w[5:0], a});
      chk(status == 8'h00, "R3", "status cleared", status, 0);
      chk(cmd_q[10], "R9", "enable while busy", cmd_q[10], 1);
      @(negedge clk);
      if (w[6]) begin
         chk(!card_req, "R3", "single request", card_req, 0);
         if (poke) begin
            cmd_wr = 1'b1; cmd_word = w ^ 11'h03F; cmd_arg = ~a;
            @(negedge clk);
            cmd_wr = 1'b0;
            chk(cmd_q == w && card_arg == a && busy, "R10", "busy write ignored",
                {cmd_q, card_arg}, {w, a});
         end
         for (int k = 0; k < nb; k++) begin
            rsp_vld = 1'b1; rsp_byte = bb[k];
            @(negedge clk);
         end
         rsp_vld = 1'b0;
         rsp_end = 1'b1; rsp_len = len;
         @(negedge clk);
         rsp_end = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(status == 0 && rsp_words == 0 && cmd_q == 0, "R1", "reset regs",
          {status, cmd_q}, 0);
      chk(!busy && !done && !card_req, "R1", "reset flags",
          {busy, done, card_req}, 0);
      issue(11'h0C5, 32'h1111_2222, 0, 8'd0, 8'h00, 1'b0);        // R2
      issue(11'h402, 32'hDEAD_0001, 0, 8'd0, 8'h00, 1'b0);        // R4
      issue(11'h451, 32'h0000_0042, 4, 8'd4, 8'hA0, 1'b0);        // R5
      issue(11'h4C2, 32'h0000_0007, 16, 8'd16, 8'h12, 1'b0);      // R6
      issue(11'h402, 32'h5, 0, 8'd0, 8'h00, 1'b0);                // R4 keeps words
      issue(11'h449, 32'h9, 0, 8'd0, 8'h00, 1'b0);                // R7 zero bytes
      issue(11'h4C3, 32'h3, 4, 8'd4, 8'h55, 1'b0);                // R7 short for long
      issue(11'h448, 32'h8, 8, 8'd8, 8'h66, 1'b0);                // R7 odd length
      issue(11'h44A, 32'hA, 16, 8'd16, 8'h33, 1'b0);              // R8
      issue(11'h4C9, 32'hCAFE_F00D, 16, 8'd16, 8'h70, 1'b1);      // R10
      issue(11'h451, 32'h1, 4, 8'd4, 8'h0F, 1'b0);                // R5 after long
      repeat (4) @(negedge clk);
      chk(sb.size() == 0 && n_pop == n_push, "R9", "all completions seen",
          n_pop, n_push);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule